// File: doc/BRIEF.md
# Conditional Stateful Read-Modify-Write ALU

This block is a packet-pipeline action unit that owns one private state word. Each time a header-vector entry arrives with its valid strobe, the unit reads the state and compares it against an operand. Based on the outcome of that comparison, it picks one of two update rules. It then writes the new state back at the same clock edge. The unit accepts one entry per clock. An update made by one entry is always seen by the entry directly behind it, so back-to-back traffic needs no stall and no forwarding.

Static configuration inputs set every choice the unit makes. This includes which operand feeds the compare and each branch, whether the state copy is forced to zero before use, the relational operator, and the add-or-subtract operator of each branch. The unit keeps its state to itself and shares it with no other unit. The word the unit presents to downstream output selectors is the state value as it stood before the update. Before traffic starts, a load port presets the state.

Top module: `cond_state_alu`

## Requirements
- R1: While reset is asserted and right after it, `state_value` equals the RESET_STATE parameter (default 0), `res_valid` is 0 and `res_data` is 0.
- R2: When `load_en` is high at a clock edge, the state takes `load_value` at that edge. This has priority over `valid`: an entry offered in the same cycle is dropped and `res_valid` is 0 on the next cycle.
- R3: When both `valid` and `load_en` are low at an edge, the state, `res_data` and `res_valid`=0 are all held and nothing updates.
- R4: Each operand selector is a 2-bit code. Code 0 picks `fld0`, code 1 picks `fld1`, and codes 2 and 3 both pick the selector's own constant, read as an unsigned value.
- R5: Each keep bit gates its own copy of the state. When the bit is 0 the copy is 0; when the bit is 1 the copy is the current state. The compare and the two branches each have an independent keep bit.
- R6: The compare code is 0 = equal, 1 = not-equal, 2 = less-than, 3 = greater-than. It tests (gated state) against (selected operand), both treated as unsigned. When the test is true, the taken branch (`tk_*`) computes the new state. Otherwise the other branch (`nt_*`) does.
- R7: Each branch has a 1-bit operator. Code 0 gives gated state plus operand; code 1 gives gated state minus operand. Both wrap modulo 2^DATA_W.
- R8: One cycle after an accepted entry (`valid` high, `load_en` low), `res_valid` is 1 and `res_data` holds the state value from before that entry's update.
- R9: With entries on consecutive cycles, each entry's compare and update use the state written by the entry directly before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_en | input | 1 | Preset the state from `load_value` |
| load_value | input | DATA_W | Preset value for the state |
| valid | input | 1 | A header-vector entry is present |
| fld0 | input | DATA_W | Packet field 0 of the entry |
| fld1 | input | DATA_W | Packet field 1 of the entry |
| cond_keep | input | 1 | Compare path keep bit (0 forces state copy to zero) |
| cond_sel | input | 2 | Compare operand selector |
| cond_const | input | DATA_W | Compare constant |
| cond_rel | input | 2 | Relational operator code |
| tk_keep | input | 1 | Taken branch keep bit |
| tk_sel | input | 2 | Taken branch operand selector |
| tk_const | input | DATA_W | Taken branch constant |
| tk_op | input | 1 | Taken branch operator (0 add, 1 subtract) |
| nt_keep | input | 1 | Not-taken branch keep bit |
| nt_sel | input | 2 | Not-taken branch operand selector |
| nt_const | input | DATA_W | Not-taken branch constant |
| nt_op | input | 1 | Not-taken branch operator (0 add, 1 subtract) |
| res_valid | output | 1 | `res_data` belongs to an accepted entry |
| res_data | output | DATA_W | State value from before the entry's update |
| state_value | output | DATA_W | Current state register |

## Verification
The bench sweeps every compare code against every keep setting and operand selector, including the reserved selector code 3. It uses operands that equal the state, which catch an equal/not-equal swap or a signed compare that a random-only sweep would miss. It also uses values near the top of the range, so an adder that fails to wrap, or a subtraction with reversed operands, gives a wrong state. Three entries go through back to back, which exposes a design that updates from a stale state copy; such a design would repeat the first entry's outcome. Two more cases are covered. A load offered together with an entry must drop the entry, otherwise the state would not equal the preset value. An idle cycle must leave both outputs untouched, otherwise `res_valid` would pulse or the state would drift.

// File: rtl/cond_state_alu_pkg.sv
package cond_state_alu_pkg;

   typedef enum logic [1:0] {
      REL_EQ = 2'd0,
      REL_NE = 2'd1,
      REL_LT = 2'd2,
      REL_GT = 2'd3
   } rel_code_e;

   typedef enum logic {
      ARITH_ADD = 1'b0,
      ARITH_SUB = 1'b1
   } arith_code_e;

   localparam int SEL_W    = 2;
   localparam int N_BRANCH = 2;
   localparam int BR_TAKEN = 0;
   localparam int BR_OTHER = 1;

endpackage

// File: rtl/sralu_opnd_mux.sv
module sralu_opnd_mux #(
   parameter int DATA_W = 32
) (
   input  logic [1:0]        sel,
   input  logic [DATA_W-1:0] fld0,
   input  logic [DATA_W-1:0] fld1,
   input  logic [DATA_W-1:0] konst,
   output logic [DATA_W-1:0] y
);
   always_comb begin
      unique case (sel)
         2'd0:    y = fld0;
         2'd1:    y = fld1;
         default: y = konst;
      endcase
   end
endmodule

// File: rtl/sralu_zero_gate.sv
module sralu_zero_gate #(
   parameter int DATA_W = 32
) (
   input  logic              keep,
   input  logic [DATA_W-1:0] a,
   output logic [DATA_W-1:0] y
);
   always_comb y = keep ? a : '0;
endmodule

// File: rtl/sralu_relcmp.sv
module sralu_relcmp
   import cond_state_alu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [1:0]        rel,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic              hit
);
   logic eq_w;
   logic lt_w;

   always_comb begin
      eq_w = (a == b);
      lt_w = (a < b);
      unique case (rel_code_e'(rel))
         REL_EQ: hit = eq_w;
         REL_NE: hit = !eq_w;
         REL_LT: hit = lt_w;
         REL_GT: hit = !lt_w && !eq_w;
         default: hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/sralu_branch.sv
module sralu_branch
   import cond_state_alu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              keep,
   input  logic [1:0]        sel,
   input  logic [DATA_W-1:0] konst,
   input  logic              op,
   input  logic [DATA_W-1:0] state,
   input  logic [DATA_W-1:0] fld0,
   input  logic [DATA_W-1:0] fld1,
   output logic [DATA_W-1:0] next_state
);
   logic [DATA_W-1:0] gated_w;
   logic [DATA_W-1:0] opnd_w;

   sralu_zero_gate #(.DATA_W(DATA_W)) gate_i (
      .keep (keep),
      .a    (state),
      .y    (gated_w)
   );

   sralu_opnd_mux #(.DATA_W(DATA_W)) mux_i (
      .sel   (sel),
      .fld0  (fld0),
      .fld1  (fld1),
      .konst (konst),
      .y     (opnd_w)
   );

   always_comb begin
      unique case (arith_code_e'(op))
         ARITH_ADD: next_state = gated_w + opnd_w;
         ARITH_SUB: next_state = gated_w - opnd_w;
         default:   next_state = gated_w;
      endcase
   end
endmodule

// File: rtl/cond_state_alu.sv
module cond_state_alu
   import cond_state_alu_pkg::*;
#(
   parameter int              DATA_W      = 32,
   parameter logic [63:0]     RESET_STATE = 64'd0,
   parameter bit              OUT_REG     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [DATA_W-1:0] load_value,
   input  logic              valid,
   input  logic [DATA_W-1:0] fld0,
   input  logic [DATA_W-1:0] fld1,
   input  logic              cond_keep,
   input  logic [1:0]        cond_sel,
   input  logic [DATA_W-1:0] cond_const,
   input  logic [1:0]        cond_rel,
   input  logic              tk_keep,
   input  logic [1:0]        tk_sel,
   input  logic [DATA_W-1:0] tk_const,
   input  logic              tk_op,
   input  logic              nt_keep,
   input  logic [1:0]        nt_sel,
   input  logic [DATA_W-1:0] nt_const,
   input  logic              nt_op,
   output logic              res_valid,
   output logic [DATA_W-1:0] res_data,
   output logic [DATA_W-1:0] state_value
);
   localparam logic [DATA_W-1:0] RST_VAL = RESET_STATE[DATA_W-1:0];

   if (DATA_W < 2 || DATA_W > 64) begin : g_bad_width
      $error("cond_state_alu: DATA_W must lie in 2..64");
   end

   logic [DATA_W-1:0] state_q;
   logic [DATA_W-1:0] cond_gated_w;
   logic [DATA_W-1:0] cond_opnd_w;
   logic              cond_hit_w;
   logic              accept_w;
   logic [DATA_W-1:0] next_w;

   logic [N_BRANCH-1:0]             br_keep;
   logic [N_BRANCH-1:0][SEL_W-1:0]  br_sel;
   logic [N_BRANCH-1:0][DATA_W-1:0] br_const;
   logic [N_BRANCH-1:0]             br_op;
   logic [N_BRANCH-1:0][DATA_W-1:0] br_next;

   always_comb begin
      br_keep[BR_TAKEN]  = tk_keep;
      br_sel[BR_TAKEN]   = tk_sel;
      br_const[BR_TAKEN] = tk_const;
      br_op[BR_TAKEN]    = tk_op;
      br_keep[BR_OTHER]  = nt_keep;
      br_sel[BR_OTHER]   = nt_sel;
      br_const[BR_OTHER] = nt_const;
      br_op[BR_OTHER]    = nt_op;
   end

   sralu_zero_gate #(.DATA_W(DATA_W)) cond_gate_i (
      .keep (cond_keep),
      .a    (state_q),
      .y    (cond_gated_w)
   );

   sralu_opnd_mux #(.DATA_W(DATA_W)) cond_mux_i (
      .sel   (cond_sel),
      .fld0  (fld0),
      .fld1  (fld1),
      .konst (cond_const),
      .y     (cond_opnd_w)
   );

   sralu_relcmp #(.DATA_W(DATA_W)) cmp_i (
      .rel (cond_rel),
      .a   (cond_gated_w),
      .b   (cond_opnd_w),
      .hit (cond_hit_w)
   );

   for (genvar g = 0; g < N_BRANCH; g++) begin : g_branch
      sralu_branch #(.DATA_W(DATA_W)) br_i (
         .keep       (br_keep[g]),
         .sel        (br_sel[g]),
         .konst      (br_const[g]),
         .op         (br_op[g]),
         .state      (state_q),
         .fld0       (fld0),
         .fld1       (fld1),
         .next_state (br_next[g])
      );
   end

   always_comb begin
      next_w   = cond_hit_w ? br_next[BR_TAKEN] : br_next[BR_OTHER];
      accept_w = valid && !load_en;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RST_VAL;
      end else if (load_en) begin
         state_q <= load_value;
      end else if (valid) begin
         state_q <= next_w;
      end
   end

   if (OUT_REG) begin : g_out_reg
      logic              rv_q;
      logic [DATA_W-1:0] rd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rv_q <= 1'b0;
            rd_q <= '0;
         end else begin
            rv_q <= accept_w;
            if (accept_w) rd_q <= state_q;
         end
      end
      assign res_valid = rv_q;
      assign res_data  = rd_q;
   end else begin : g_out_comb
      assign res_valid = accept_w;
      assign res_data  = state_q;
   end

   assign state_value = state_q;

endmodule

// File: rtl/cond_state_alu_chk.sv
module cond_state_alu_chk #(
   parameter int DATA_W  = 32,
   parameter bit OUT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              load_en,
   input logic [DATA_W-1:0] load_value,
   input logic              valid,
   input logic              res_valid,
   input logic [DATA_W-1:0] res_data,
   input logic [DATA_W-1:0] state_value
);
   // R2
   load_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> state_value == $past(load_value));

   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en && !valid) |=> $stable(state_value));

   if (OUT_REG) begin : g_reg_chk
      // R8
      res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (valid && !load_en) |=> res_valid);

      // R8
      res_old_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (valid && !load_en) |=> res_data == $past(state_value));

      // R2
      load_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
         load_en |=> !res_valid);

      // R3
      res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(valid && !load_en) |=> $stable(res_data));
   end
endmodule

bind cond_state_alu cond_state_alu_chk #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .load_en     (load_en),
   .load_value  (load_value),
   .valid       (valid),
   .res_valid   (res_valid),
   .res_data    (res_data),
   .state_value (state_value)
);

// File: tb/cond_state_alu_tb_top.sv
module cond_state_alu_tb_top;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         load_en = 1'b0;
   logic [W-1:0] load_value = '0;
   logic         valid = 1'b0;
   logic [W-1:0] fld0 = '0, fld1 = '0;
   logic         cond_keep = 1'b0;
   logic [1:0]   cond_sel = '0;
   logic [W-1:0] cond_const = '0;
   logic [1:0]   cond_rel = '0;
   logic         tk_keep = 1'b0, nt_keep = 1'b0;
   logic [1:0]   tk_sel = '0, nt_sel = '0;
   logic [W-1:0] tk_const = '0, nt_const = '0;
   logic         tk_op = 1'b0, nt_op = 1'b0;
   logic         res_valid;
   logic [W-1:0] res_data;
   logic [W-1:0] state_value;

   int errors = 0;
   int checks = 0;
   logic [W-1:0] seed = 32'h1234_5678;

   always #4 clk = ~clk;

   cond_state_alu #(.DATA_W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_value(load_value),
      .valid(valid), .fld0(fld0), .fld1(fld1),
      .cond_keep(cond_keep), .cond_sel(cond_sel), .cond_const(cond_const), .cond_rel(cond_rel),
      .tk_keep(tk_keep), .tk_sel(tk_sel), .tk_const(tk_const), .tk_op(tk_op),
      .nt_keep(nt_keep), .nt_sel(nt_sel), .nt_const(nt_const), .nt_op(nt_op),
      .res_valid(res_valid), .res_data(res_data), .state_value(state_value)
   );

   function automatic logic [W-1:0] rnd();
      seed = seed * 32'd1103515245 + 32'd12345;
      return {seed[15:0], seed[31:16]};
   endfunction

   function automatic logic [W-1:0] pick(input logic [1:0] s, input logic [W-1:0] a,
                                         input logic [W-1:0] b, input logic [W-1:0] k);
      if (s == 2'd0) return a;
      if (s == 2'd1) return b;
      return k;
   endfunction

   function automatic logic [W-1:0] model_next(input logic [W-1:0] s);
      logic [W-1:0] cs, co, bs, bo;
      logic         t;
      cs = cond_keep ? s : '0;
      co = pick(cond_sel, fld0, fld1, cond_const);
      case (cond_rel)
         2'd0: t = (cs == co);
         2'd1: t = (cs != co);
         2'd2: t = (cs < co);
         default: t = (cs > co);
      endcase
      if (t) begin
         bs = tk_keep ? s : '0;
         bo = pick(tk_sel, fld0, fld1, tk_const);
         return tk_op ? bs - bo : bs + bo;
      end
      bs = nt_keep ? s : '0;
      bo = pick(nt_sel, fld0, fld1, nt_const);
      return nt_op ? bs - bo : bs + bo;
   endfunction

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #1_600_000;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      finish_run();
   end

   initial begin
      logic [W-1:0] exp_state, exp_res, base;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 state", state_value, '0);
      check("R1 res_valid", {31'd0, res_valid}, '0);
      check("R1 res_data", res_data, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", state_value, '0);
      exp_res = '0;

      for (int rel = 0; rel < 4; rel++)
      for (int ck = 0; ck < 2; ck++)
      for (int cs = 0; cs < 4; cs++)
      for (int aop = 0; aop < 2; aop++)
      for (int ak = 0; ak < 2; ak++)
      for (int as = 0; as < 3; as++) begin
         cond_rel = 2'(rel); cond_keep = 1'(ck); cond_sel = 2'(cs);
         tk_op = 1'(aop); tk_keep = 1'(ak); tk_sel = 2'(as);
         nt_op = ~tk_op; nt_keep = ~tk_keep; nt_sel = 2'((as + 1) % 4);
         base = (as == 0) ? (32'hFFFF_FFF0 + 32'(rel)) : rnd();
         cond_const = (cs == 3) ? base : 32'(rel * 7);
         tk_const = 32'hFFFF_FF00 + 32'(cs);
         nt_const = 32'(ck * 5 + 1);
         // R2 load with a competing entry
         load_en = 1'b1; load_value = base; valid = 1'b1; fld0 = rnd(); fld1 = rnd();
         @(negedge clk);
         load_en = 1'b0;
         exp_state = base;
         check("R2 load value", state_value, exp_state);
         check("R2 entry dropped", {31'd0, res_valid}, '0);
         // R9 three back-to-back entries
         for (int k = 0; k < 3; k++) begin
            valid = 1'b1;
            fld0 = (k == 0) ? exp_state : rnd();
            fld1 = (k == 1) ? exp_state : rnd();
            exp_res = exp_state;
            exp_state = model_next(exp_state);
            @(negedge clk);
            check("R4 R5 R6 R7 R9 state update", state_value, exp_state);
            check("R8 res_data", res_data, exp_res);
            check("R8 res_valid", {31'd0, res_valid}, 32'd1);
         end
         // R3 idle cycle
         valid = 1'b0; fld0 = rnd(); fld1 = rnd();
         @(negedge clk);
         check("R3 state hold", state_value, exp_state);
         check("R3 res_data hold", res_data, exp_res);
         check("R3 res_valid low", {31'd0, res_valid}, '0);
      end

      // R7 explicit wrap cases
      cond_rel = 2'd0; cond_keep = 1'b0; cond_sel = 2'd2; cond_const = '0;
      tk_keep = 1'b1; tk_sel = 2'd0; tk_op = 1'b0;
      load_en = 1'b1; load_value = 32'hFFFF_FFFF; valid = 1'b0;
      @(negedge clk);
      load_en = 1'b0; valid = 1'b1; fld0 = 32'd2;
      @(negedge clk);
      check("R7 add wrap", state_value, 32'd1);
      tk_op = 1'b1; fld0 = 32'd3;
      @(negedge clk);
      check("R7 sub wrap", state_value, 32'hFFFF_FFFE);
      valid = 1'b0;
      @(negedge clk);
      finish_run();
   end
endmodule